// File: doc/BRIEF.md
# Two-Level ALU Operation Decoder

This block is the second stage of a split instruction decoder. The main controller looks only at the opcode and reduces each instruction to a 2-bit operation class. This block combines that class with the 6-bit function field of a register-format instruction and produces the 4-bit operation select that drives the ALU. The class alone either forces an addition or a subtraction, or it passes the choice of operation to the function field.

The block is purely combinational and has no state. Memory-access instructions need an addition to form an address. Equality branches need a subtraction so that the ALU's zero flag can be tested. Register-format instructions pick AND, OR, add, subtract or set-on-less-than from their function field. The reserved class and any function code outside the supported set fall back to addition, so the output is always a defined, harmless operation. The ALU's NOR encoding is never generated.

Top module: `alu_op_decoder`

## Requirements
- R1: Class code 00 (memory access) outputs add, 4'b0010, whatever the function field holds.
- R2: Class code 01 (equality branch) outputs subtract, 4'b0110, whatever the function field holds.
- R3: With class code 10 (register format), function 6'b100000 outputs add 4'b0010 and function 6'b100010 outputs subtract 4'b0110.
- R4: With class code 10, function 6'b100100 outputs AND 4'b0000 and function 6'b100101 outputs OR 4'b0001.
- R5: With class code 10, function 6'b101010 outputs set-on-less-than 4'b0111.
- R6: With class code 10, every function code other than the five above outputs add, 4'b0010.
- R7: Class code 11 (reserved) outputs add, 4'b0010, whatever the function field holds.
- R8: The NOR encoding 4'b1100 is never output, and the output is always one of 4'b0000, 4'b0001, 4'b0010, 4'b0110 or 4'b0111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of the current instruction |
| alu_ctl_o | output | 4 | ALU operation select |

## Verification
A vector table first applies each of the five supported function codes under the register-format class. This separates the five operations from each other. The same codes are then applied under the memory, branch and reserved classes, which shows that the class code overrides the function field. Near-miss function codes that differ from a supported code in one bit show that the match is exact and that misses fall back to addition. A full sweep of all 256 class and function pairs then covers every unsupported code and confirms that NOR never appears.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

    localparam int CLASS_W = 2;
    localparam int FN_W    = 6;
    localparam int CTL_W   = 4;
    localparam int N_FN    = 5;

    typedef enum logic [CTL_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM  = 2'b00,
        CLS_BEQ  = 2'b01,
        CLS_REG  = 2'b10,
        CLS_RSVD = 2'b11
    } op_class_e;

    typedef struct packed {
        logic    known;
        alu_op_e op;
    } fn_dec_t;

    typedef struct packed {
        op_class_e cls;
        logic      use_field;
        alu_op_e   forced_op;
    } class_dec_t;

    localparam logic [FN_W-1:0] FN_CODE [N_FN] = '{
        6'b100100, 6'b100101, 6'b100000, 6'b100010, 6'b101010
    };

    localparam alu_op_e FN_OP [N_FN] = '{
        ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT
    };

    localparam alu_op_e SAFE_OP = ALU_ADD;

    function automatic alu_op_e class_forced_op(input op_class_e c);
        alu_op_e r;
        case (c)
            CLS_BEQ: r = ALU_SUB;
            default: r = SAFE_OP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aluop_class_dec.sv
module aluop_class_dec
    import alu_ctl_pkg::*;
(
    input  logic [CLASS_W-1:0] class_code_i,
    output class_dec_t         cdec_o
);
    op_class_e cls;

    always_comb begin
        cls = op_class_e'(class_code_i);
        cdec_o.cls       = cls;
        cdec_o.use_field = (cls == CLS_REG);
        cdec_o.forced_op = class_forced_op(cls);
    end
endmodule

// File: rtl/funct_field_dec.sv
module funct_field_dec
    import alu_ctl_pkg::*;
(
    input  logic [FN_W-1:0] fn_i,
    output fn_dec_t         fdec_o
);
    logic [N_FN-1:0] hit;

    for (genvar g = 0; g < N_FN; g++) begin : g_match
        assign hit[g] = (fn_i == FN_CODE[g]);
    end

    always_comb begin
        fdec_o.known = |hit;
        fdec_o.op    = SAFE_OP;
        for (int k = 0; k < N_FN; k++) begin
            if (hit[k]) fdec_o.op = FN_OP[k];
        end
    end
endmodule

// File: rtl/alu_op_select.sv
module alu_op_select
    import alu_ctl_pkg::*;
(
    input  class_dec_t cdec_i,
    input  fn_dec_t    fdec_i,
    output alu_op_e    op_o
);
    logic cls_is_reg;

    assign cls_is_reg = (cdec_i.cls == CLS_REG);

    always_comb begin
        if (cdec_i.use_field && cls_is_reg) begin
            op_o = fdec_i.known ? fdec_i.op : SAFE_OP;
        end else begin
            op_o = cdec_i.forced_op;
        end
    end
endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_ctl_pkg::*;
(
    input  logic [1:0] op_class_i,
    input  logic [5:0] funct_i,
    output logic [3:0] alu_ctl_o
);
    class_dec_t cdec;
    fn_dec_t    fdec;
    alu_op_e    op_sel;

    aluop_class_dec u_class (
        .class_code_i (op_class_i),
        .cdec_o       (cdec)
    );

    funct_field_dec u_field (
        .fn_i   (funct_i),
        .fdec_o (fdec)
    );

    alu_op_select u_sel (
        .cdec_i (cdec),
        .fdec_i (fdec),
        .op_o   (op_sel)
    );

    assign alu_ctl_o = op_sel;
endmodule

// File: rtl/alu_op_decoder_chk.sv
module alu_op_decoder_chk (
    input logic [1:0] op_class_i,
    input logic [5:0] funct_i,
    input logic [3:0] alu_ctl_o
);
    logic known_fn;
    assign known_fn = (funct_i == 6'b100000) || (funct_i == 6'b100010) ||
                      (funct_i == 6'b100100) || (funct_i == 6'b100101) ||
                      (funct_i == 6'b101010);

    always_comb begin
        if (!$isunknown({op_class_i, funct_i, alu_ctl_o})) begin
            if (op_class_i == 2'b00)
                a_r1_mem_add: assert (alu_ctl_o == 4'b0010);
            if (op_class_i == 2'b01)
                a_r2_branch_sub: assert (alu_ctl_o == 4'b0110);
            if (op_class_i == 2'b10 && funct_i == 6'b100010)
                a_r3_reg_sub: assert (alu_ctl_o == 4'b0110);
            if (op_class_i == 2'b10 && funct_i == 6'b100101)
                a_r4_reg_or: assert (alu_ctl_o == 4'b0001);
            if (op_class_i == 2'b10 && funct_i == 6'b101010)
                a_r5_reg_slt: assert (alu_ctl_o == 4'b0111);
            if (op_class_i == 2'b10 && !known_fn)
                a_r6_unknown_add: assert (alu_ctl_o == 4'b0010);
            if (op_class_i == 2'b11)
                a_r7_reserved_add: assert (alu_ctl_o == 4'b0010);
            a_r8_no_nor: assert (alu_ctl_o != 4'b1100);
        end
    end
endmodule

bind alu_op_decoder alu_op_decoder_chk u_chk (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .alu_ctl_o  (alu_ctl_o)
);

// File: tb/tb_alu_op_decoder.sv
`timescale 1ns/100ps
module tb_alu_op_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_class;
    logic [5:0] funct;
    logic [3:0] alu_ctl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_op_decoder dut (
        .op_class_i (op_class),
        .funct_i    (funct),
        .alu_ctl_o  (alu_ctl)
    );

    // {class, funct, expected, tag index}
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {2'b10, 6'b100000, 4'b0010, 4'd3},
        {2'b10, 6'b100010, 4'b0110, 4'd3},
        {2'b10, 6'b100100, 4'b0000, 4'd4},
        {2'b10, 6'b100101, 4'b0001, 4'd4},
        {2'b10, 6'b101010, 4'b0111, 4'd5},
        {2'b10, 6'b100001, 4'b0010, 4'd6},
        {2'b10, 6'b101011, 4'b0010, 4'd6},
        {2'b10, 6'b000000, 4'b0010, 4'd6},
        {2'b10, 6'b100111, 4'b0010, 4'd6},
        {2'b00, 6'b100010, 4'b0010, 4'd1},
        {2'b00, 6'b100100, 4'b0010, 4'd1},
        {2'b01, 6'b100000, 4'b0110, 4'd2},
        {2'b01, 6'b101010, 4'b0110, 4'd2},
        {2'b11, 6'b100100, 4'b0110 ^ 4'b0100, 4'd7},
        {2'b11, 6'b101010, 4'b0010, 4'd7},
        {2'b01, 6'b111111, 4'b0110, 4'd2}
    };

    function automatic logic [3:0] model(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b01) return 4'b0110;
        if (c != 2'b10) return 4'b0010;
        case (f)
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b101010: return 4'b0111;
            default:   return 4'b0010;
        endcase
    endfunction

    function automatic int tag_of(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 1;
        if (c == 2'b01) return 2;
        if (c == 2'b11) return 7;
        case (f)
            6'b100000, 6'b100010: return 3;
            6'b100100, 6'b100101: return 4;
            6'b101010:            return 5;
            default:              return 6;
        endcase
    endfunction

    task automatic apply_check(input logic [1:0] c, input logic [5:0] f,
                               input logic [3:0] exp, input int tag);
        @(posedge clk);
        op_class = c;
        funct    = f;
        @(negedge clk);
        n_chk++;
        if (alu_ctl !== exp) begin
            n_fail++;
            $display("FAIL R%0d class=%b funct=%b actual=%b expected=%b",
                     tag, c, f, alu_ctl, exp);
        end
    endtask

    initial begin
        op_class = 2'b00;
        funct    = 6'b000000;
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs give add (R1)
        @(negedge clk);
        n_chk++;
        if (alu_ctl !== 4'b0010) begin
            n_fail++;
            $display("FAIL R1 reset-state actual=%b expected=%b", alu_ctl, 4'b0010);
        end
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][15:14], VEC[i][13:8], VEC[i][7:4], int'(VEC[i][3:0]));
        end

        // exhaustive sweep of every class/function pair (R1..R7), NOR check (R8)
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                apply_check(2'(c), 6'(f), model(2'(c), 6'(f)), tag_of(2'(c), 6'(f)));
                n_chk++;
                if (alu_ctl === 4'b1100 ||
                    !(alu_ctl inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111})) begin
                    n_fail++;
                    $display("FAIL R8 class=%0d funct=%0d actual=%b expected=legal non-NOR",
                             c, f, alu_ctl);
                end
            end
        end

        // back-to-back class changes with a fixed function field (R1, R2, R7)
        apply_check(2'b10, 6'b100101, 4'b0001, 4);
        apply_check(2'b00, 6'b100101, 4'b0010, 1);
        apply_check(2'b01, 6'b100101, 4'b0110, 2);
        apply_check(2'b11, 6'b100101, 4'b0010, 7);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule